// File: doc/BRIEF.md
# Merging Miss Tracker

This block sits between a cache's miss path and the next memory level and keeps track of misses that are still waiting for data. It holds a fixed number of primary entries, one per distinct block address in flight. Each entry owns a short ordered list of secondary requests; every secondary records who asked (requester ID), a requester tag and the byte offset inside the block. A miss whose block is already tracked is appended to that block's list. A miss to an untracked block takes a free entry and causes exactly one fetch toward the lower level.

When the lower level returns a fill for a tracked block, the entry switches to draining. Its queued requests are then replayed one per cycle on a response port with a valid/ready handshake, oldest first. When the last one is taken, the whole entry is freed in one step. The other entries are not moved. The upstream side sees a single ready signal. It drops when a request cannot be taken: no free entry for a new block, a full secondary list, or a block whose entry is already draining.

Top module: `mshr_merge`

## Requirements
- R1: When every primary entry is valid and the request's block matches none of them, `req_ready_o` is 0 and the request is not taken.
- R2: Two addresses are the same block when they agree in all bits above the low `OFF_W` offset bits (16-bit address, 4 offset bits by default). Addresses that differ only in those bits share one entry and one fetch. Addresses that differ above them use separate entries.
- R3: A request taken for a block that already has a non-draining entry is appended to the end of that entry's list and causes no fetch.
- R4: A request taken for an untracked block allocates an entry. In the next cycle `fetch_valid_o` is 1 for one cycle, and `fetch_blk_o` equals the request address with the offset bits removed.
- R5: A request that matches an entry already holding `N_SEC` secondaries sees `req_ready_o` at 0.
- R6: After a fill for a tracked block, every request queued under that block is presented on the response port, in the order of arrival. Each carries `rsp_blk_o` and the ID, tag and offset it arrived with. Once one block has started, its responses are not interleaved with those of another block.
- R7: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, the response outputs hold their values on the next cycle.
- R8: The entry is freed at the clock edge where its last response is accepted. From the next cycle it can be allocated again.
- R9: A fill whose block matches no entry, or only an entry that is already draining, has no effect. No response is produced for it.
- R10: A request that matches a draining entry sees `req_ready_o` at 0 until that entry is freed. After that, the same block is allocated anew and fetched again.
- R11: After reset, `req_ready_o` is 1, and `rsp_valid_o` and `fetch_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request present |
| req_addr_i | input | ADDR_W | Miss byte address |
| req_id_i | input | ID_W | Requester ID |
| req_tag_i | input | TAG_W | Requester tag |
| req_ready_o | output | 1 | Request can be taken this cycle (low means back pressure) |
| fetch_valid_o | output | 1 | One-cycle pulse: fetch a block from the lower level |
| fetch_blk_o | output | ADDR_W-OFF_W | Block address to fetch |
| fill_valid_i | input | 1 | Fill arrived from the lower level |
| fill_blk_i | input | ADDR_W-OFF_W | Block address of the fill |
| rsp_valid_o | output | 1 | Replayed request present |
| rsp_ready_i | input | 1 | Downstream accepts the replayed request |
| rsp_blk_o | output | ADDR_W-OFF_W | Block of the replayed request |
| rsp_id_o | output | ID_W | Requester ID of the replayed request |
| rsp_tag_o | output | TAG_W | Requester tag of the replayed request |
| rsp_off_o | output | OFF_W | Byte offset of the replayed request |

## Verification
Some rules hold on every cycle, and the checker watches those. Ready must be low when the table is full with no match, when the matched list is full, and when the matched entry is draining. A fetch follows an allocation and never follows a merge. A held response keeps its values, and a response appears only while some entry is draining. Other behaviour spans many cycles, and only the bench's scenarios show it: replay in arrival order with the right fields, the block-aligned merge decision, a slot reused exactly one cycle after it is freed, fills that are ignored, and a block fetched again after its entry drains.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mshr_pick.sv
module mshr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/mshr_match.sv
module mshr_match #(
  parameter int N  = 4,
  parameter int BW = 12
) (
  input  logic [N-1:0]  valid_i,
  input  logic [BW-1:0] blk_i [N],
  input  logic [BW-1:0] key_i,
  output logic [N-1:0]  hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_o[i] = valid_i[i] && (blk_i[i] == key_i);
  end
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry
  import mshr_pkg::*;
#(
  parameter int BLK_W = 12,
  parameter int REC_W = 11,
  parameter int N_SEC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             push_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [REC_W-1:0] rec_i,
  input  logic             fill_i,
  input  logic             pop_i,
  output logic             valid_o,
  output logic             drain_o,
  output logic [BLK_W-1:0] blk_o,
  output logic             full_o,
  output logic             last_o,
  output logic [REC_W-1:0] head_o
);
  localparam int PTR_W = idx_w(N_SEC);
  localparam int CNT_W = $clog2(N_SEC + 1);

  logic [REC_W-1:0] slot_q [N_SEC];
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] rd_q;
  logic             valid_q, drain_q;
  logic [BLK_W-1:0] blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      drain_q <= 1'b0;
      blk_q   <= '0;
      cnt_q   <= '0;
      rd_q    <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      drain_q <= 1'b0;
      blk_q   <= blk_i;
      cnt_q   <= CNT_W'(1);
      rd_q    <= '0;
    end else begin
      if (push_i) cnt_q <= cnt_q + CNT_W'(1);
      if (fill_i) drain_q <= 1'b1;
      if (pop_i) begin
        if (last_o) begin
          valid_q <= 1'b0;
          drain_q <= 1'b0;
          cnt_q   <= '0;
          rd_q    <= '0;
        end else begin
          rd_q <= rd_q + PTR_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_SEC; k++) slot_q[k] <= '0;
    end else if (alloc_i) begin
      slot_q[0] <= rec_i;
    end else if (push_i) begin
      slot_q[PTR_W'(cnt_q)] <= rec_i;
    end
  end

  assign valid_o = valid_q;
  assign drain_o = drain_q;
  assign blk_o   = blk_q;
  assign full_o  = (cnt_q == CNT_W'(N_SEC));
  assign last_o  = ((CNT_W'(rd_q) + CNT_W'(1)) == cnt_q);
  assign head_o  = slot_q[rd_q];
endmodule

// File: rtl/mshr_merge.sv
module mshr_merge
  import mshr_pkg::*;
#(
  parameter int N_PRI  = 4,
  parameter int N_SEC  = 4,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int ID_W   = 3,
  parameter int TAG_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [ID_W-1:0]         req_id_i,
  input  logic [TAG_W-1:0]        req_tag_i,
  output logic                    req_ready_o,
  output logic                    fetch_valid_o,
  output logic [ADDR_W-OFF_W-1:0] fetch_blk_o,
  input  logic                    fill_valid_i,
  input  logic [ADDR_W-OFF_W-1:0] fill_blk_i,
  output logic                    rsp_valid_o,
  input  logic                    rsp_ready_i,
  output logic [ADDR_W-OFF_W-1:0] rsp_blk_o,
  output logic [ID_W-1:0]         rsp_id_o,
  output logic [TAG_W-1:0]        rsp_tag_o,
  output logic [OFF_W-1:0]        rsp_off_o
);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int REC_W = ID_W + TAG_W + OFF_W;
  localparam int PI_W  = idx_w(N_PRI);

  logic [N_PRI-1:0] ent_valid, ent_drain, ent_full, ent_last;
  logic [N_PRI-1:0] req_hit, fill_hit, ent_free;
  logic [BLK_W-1:0] ent_blk  [N_PRI];
  logic [REC_W-1:0] ent_head [N_PRI];

  logic [BLK_W-1:0] req_blk;
  logic [REC_W-1:0] req_rec;
  logic             hit_any, free_any, drain_any;
  logic [PI_W-1:0]  hit_idx, free_idx, drain_idx;
  logic             hit_stall, acc, acc_new;

  logic             busy_q;
  logic [PI_W-1:0]  cur_q;
  logic             fetch_valid_q;
  logic [BLK_W-1:0] fetch_blk_q;
  logic [REC_W-1:0] cur_rec;

  assign req_blk  = req_addr_i[ADDR_W-1:OFF_W];
  assign req_rec  = {req_id_i, req_tag_i, req_addr_i[OFF_W-1:0]};
  assign ent_free = ~ent_valid;

  mshr_match #(.N(N_PRI), .BW(BLK_W)) u_req_match (
    .valid_i(ent_valid), .blk_i(ent_blk), .key_i(req_blk), .hit_o(req_hit)
  );

  // fills only arm entries not yet draining
  mshr_match #(.N(N_PRI), .BW(BLK_W)) u_fill_match (
    .valid_i(ent_valid & ~ent_drain), .blk_i(ent_blk), .key_i(fill_blk_i), .hit_o(fill_hit)
  );

  mshr_pick #(.N(N_PRI), .IW(PI_W)) u_pick_hit (
    .req_i(req_hit), .any_o(hit_any), .idx_o(hit_idx)
  );
  mshr_pick #(.N(N_PRI), .IW(PI_W)) u_pick_free (
    .req_i(ent_free), .any_o(free_any), .idx_o(free_idx)
  );
  mshr_pick #(.N(N_PRI), .IW(PI_W)) u_pick_drain (
    .req_i(ent_drain), .any_o(drain_any), .idx_o(drain_idx)
  );

  assign hit_stall   = ent_full[hit_idx] | ent_drain[hit_idx];
  assign req_ready_o = hit_any ? ~hit_stall : free_any;
  assign acc         = req_valid_i & req_ready_o;
  assign acc_new     = acc & ~hit_any;

  for (genvar i = 0; i < N_PRI; i++) begin : g_ent
    mshr_entry #(.BLK_W(BLK_W), .REC_W(REC_W), .N_SEC(N_SEC)) u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .alloc_i (acc_new && (free_idx == PI_W'(i))),
      .push_i  (acc && hit_any && (hit_idx == PI_W'(i))),
      .blk_i   (req_blk),
      .rec_i   (req_rec),
      .fill_i  (fill_valid_i && fill_hit[i]),
      .pop_i   (busy_q && rsp_ready_i && (cur_q == PI_W'(i))),
      .valid_o (ent_valid[i]),
      .drain_o (ent_drain[i]),
      .blk_o   (ent_blk[i]),
      .full_o  (ent_full[i]),
      .last_o  (ent_last[i]),
      .head_o  (ent_head[i])
    );
  end

  // lock onto one draining entry until its list is empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else if (!busy_q) begin
      if (drain_any) begin
        busy_q <= 1'b1;
        cur_q  <= drain_idx;
      end
    end else if (rsp_ready_i && ent_last[cur_q]) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_valid_q <= 1'b0;
      fetch_blk_q   <= '0;
    end else begin
      fetch_valid_q <= acc_new;
      if (acc_new) fetch_blk_q <= req_blk;
    end
  end

  assign fetch_valid_o = fetch_valid_q;
  assign fetch_blk_o   = fetch_blk_q;

  assign cur_rec     = ent_head[cur_q];
  assign rsp_valid_o = busy_q;
  assign rsp_blk_o   = ent_blk[cur_q];
  assign rsp_id_o    = cur_rec[REC_W-1 -: ID_W];
  assign rsp_tag_o   = cur_rec[OFF_W +: TAG_W];
  assign rsp_off_o   = cur_rec[OFF_W-1:0];
endmodule

// File: rtl/mshr_merge_chk.sv
module mshr_merge_chk #(
  parameter int N_PRI = 4,
  parameter int BLK_W = 12,
  parameter int ID_W  = 3,
  parameter int TAG_W = 4,
  parameter int OFF_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             fetch_valid_o,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic [BLK_W-1:0] rsp_blk_o,
  input logic [ID_W-1:0]  rsp_id_o,
  input logic [TAG_W-1:0] rsp_tag_o,
  input logic [OFF_W-1:0] rsp_off_o,
  input logic [N_PRI-1:0] ent_valid,
  input logic [N_PRI-1:0] ent_full,
  input logic [N_PRI-1:0] ent_drain,
  input logic [N_PRI-1:0] req_hit
);
  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (&ent_valid) && !(|req_hit)) |-> !req_ready_o); // R1
  AST_SEC_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (|(req_hit & ent_full))) |-> !req_ready_o); // R5
  AST_DRAIN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(req_hit & ent_drain)) |-> !req_ready_o); // R10
  AST_FETCH_ON_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !(|req_hit)) |=> fetch_valid_o); // R4
  AST_NO_FETCH_ON_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (|req_hit)) |=> !fetch_valid_o); // R3
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_blk_o) && $stable(rsp_id_o)
      && $stable(rsp_tag_o) && $stable(rsp_off_o))); // R7
  AST_RSP_ONLY_DRAINING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (|ent_drain)); // R6
endmodule

bind mshr_merge mshr_merge_chk #(
  .N_PRI(N_PRI), .BLK_W(ADDR_W - OFF_W), .ID_W(ID_W), .TAG_W(TAG_W), .OFF_W(OFF_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .fetch_valid_o(fetch_valid_o), .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
  .rsp_blk_o(rsp_blk_o), .rsp_id_o(rsp_id_o), .rsp_tag_o(rsp_tag_o), .rsp_off_o(rsp_off_o),
  .ent_valid(ent_valid), .ent_full(ent_full), .ent_drain(ent_drain), .req_hit(req_hit)
);

// File: tb/mshr_merge_tb_top.sv
module mshr_merge_tb_top;
  localparam int N_PRI = 4, N_SEC = 4, ADDR_W = 16, OFF_W = 4, ID_W = 3, TAG_W = 4;
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int MS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, fill_valid = 0, rsp_ready = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [ID_W-1:0] req_id = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [BLK_W-1:0] fill_blk = '0;
  logic req_ready, fetch_valid, rsp_valid;
  logic [BLK_W-1:0] fetch_blk, rsp_blk;
  logic [ID_W-1:0] rsp_id;
  logic [TAG_W-1:0] rsp_tag;
  logic [OFF_W-1:0] rsp_off;

  always #10 clk = ~clk;

  mshr_merge #(.N_PRI(N_PRI), .N_SEC(N_SEC), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
               .ID_W(ID_W), .TAG_W(TAG_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_id_i(req_id), .req_tag_i(req_tag), .req_ready_o(req_ready),
    .fetch_valid_o(fetch_valid), .fetch_blk_o(fetch_blk), .fill_valid_i(fill_valid),
    .fill_blk_i(fill_blk), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_blk_o(rsp_blk), .rsp_id_o(rsp_id), .rsp_tag_o(rsp_tag), .rsp_off_o(rsp_off)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model: slots unrelated to the design's entry numbering
  bit m_v [MS];
  bit m_dr [MS];
  logic [BLK_W-1:0] m_blk [MS];
  int m_cnt [MS];
  int m_hd [MS];
  logic [ID_W+TAG_W+OFF_W-1:0] m_q [MS][N_SEC];
  int lock = -1;
  int idle = 0;
  bit exp_fv = 0;
  logic [BLK_W-1:0] exp_fb = '0;

  task automatic chk(input bit ok, input string lbl, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
    end
  endtask

  function automatic int find(input logic [BLK_W-1:0] b);
    for (int s = 0; s < MS; s++) if (m_v[s] && m_blk[s] == b) return s;
    return -1;
  endfunction

  function automatic int nvalid();
    int n = 0;
    for (int s = 0; s < MS; s++) if (m_v[s]) n++;
    return n;
  endfunction

  function automatic bit any_drain();
    for (int s = 0; s < MS; s++) if (m_v[s] && m_dr[s]) return 1;
    return 0;
  endfunction

  // one cycle; called and returns at a falling edge
  task automatic cyc(input bit rv, input logic [ADDR_W-1:0] ra, input logic [ID_W-1:0] rid,
                     input logic [TAG_W-1:0] rtg, input bit fv, input logic [BLK_W-1:0] fb,
                     input bit rr, input string lbl);
    int s, f, rs, ns;
    bit erdy, acc;
    logic [BLK_W-1:0] b;
    string why;
    chk(fetch_valid == exp_fv, {lbl, " R4 fetch_valid"}, fetch_valid, exp_fv);
    if (exp_fv) chk(fetch_blk == exp_fb, {lbl, " R4 fetch_blk"}, fetch_blk, exp_fb);
    req_valid = rv; req_addr = ra; req_id = rid; req_tag = rtg;
    fill_valid = fv; fill_blk = fb; rsp_ready = rr;
    #1;
    b = ra[ADDR_W-1:OFF_W];
    s = find(b);
    if (s >= 0) begin
      erdy = !(m_dr[s] || m_cnt[s] == N_SEC);
      why = m_dr[s] ? " R10" : (erdy ? " R3" : " R5");
    end else begin
      erdy = (nvalid() < N_PRI);
      why = " R1";
    end
    if (rv) chk(req_ready == erdy, {lbl, why, " req_ready"}, req_ready, erdy);
    rs = -1;
    if (rsp_valid) begin
      idle = 0;
      if (lock >= 0) rs = lock;
      else for (int k = 0; k < MS; k++) if (m_v[k] && m_dr[k] && m_blk[k] == rsp_blk) rs = k;
      chk(rs >= 0, {lbl, " R9 response without draining block"}, rsp_blk, 0);
      if (rs >= 0) begin
        chk(rsp_blk == m_blk[rs], {lbl, " R6 rsp_blk"}, rsp_blk, m_blk[rs]);
        chk({rsp_id, rsp_tag, rsp_off} == m_q[rs][m_hd[rs]], {lbl, " R6 R7 rsp fields"},
            {rsp_id, rsp_tag, rsp_off}, m_q[rs][m_hd[rs]]);
        lock = rs;
      end
    end else if (any_drain()) begin
      idle++;
      if (idle > 3) begin
        chk(0, {lbl, " R6 draining block not replayed"}, 0, 1);
        idle = 0;
      end
    end
    f = find(fb);
    acc = rv && req_ready;
    exp_fv = 0;
    if (acc) begin
      if (s >= 0) begin
        m_q[s][m_cnt[s]] = {rid, rtg, ra[OFF_W-1:0]};
        m_cnt[s]++;
      end else begin
        ns = -1;
        for (int k = MS - 1; k >= 0; k--) if (!m_v[k]) ns = k;
        m_v[ns] = 1; m_dr[ns] = 0; m_blk[ns] = b; m_cnt[ns] = 1; m_hd[ns] = 0;
        m_q[ns][0] = {rid, rtg, ra[OFF_W-1:0]};
        exp_fv = 1; exp_fb = b;
      end
    end
    if (rs >= 0 && rr) begin
      m_hd[rs]++;
      if (m_hd[rs] == m_cnt[rs]) begin
        m_v[rs] = 0; m_dr[rs] = 0; lock = -1;
      end
    end
    if (fv && f >= 0 && !m_dr[f]) m_dr[f] = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int fb_i;
    for (int s = 0; s < MS; s++) begin m_v[s] = 0; m_dr[s] = 0; end
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 req_ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R11 rsp_valid after reset", rsp_valid, 0);
    chk(fetch_valid == 1'b0, "R11 fetch_valid after reset", fetch_valid, 0);

    cyc(1, 16'h0123, 1, 1, 0, 0, 0, "R2");
    cyc(1, 16'h012F, 2, 2, 0, 0, 0, "R2");
    cyc(1, 16'h0133, 3, 3, 0, 0, 0, "R2");
    cyc(1, 16'h0125, 4, 4, 0, 0, 0, "R3");
    cyc(1, 16'h0127, 5, 5, 0, 0, 0, "R3");
    cyc(1, 16'h0121, 6, 6, 0, 0, 0, "R5");
    cyc(1, 16'h0140, 7, 7, 0, 0, 0, "R4");
    cyc(1, 16'h0150, 0, 8, 0, 0, 0, "R4");
    cyc(1, 16'h0160, 1, 9, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 1, 12'h3FF, 1, "R9");
    repeat (3) cyc(0, 0, 0, 0, 0, 0, 1, "R9");
    cyc(0, 0, 0, 0, 1, 12'h012, 0, "R7");
    repeat (3) cyc(1, 16'h0125, 2, 2, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 1, 12'h012, 0, "R9");
    repeat (3) cyc(1, 16'h0160, 3, 3, 0, 0, 1, "R6");
    repeat (4) cyc(1, 16'h0160, 4, 4, 0, 0, 1, "R8");
    repeat (2) cyc(1, 16'h0126, 5, 5, 0, 0, 1, "R10");

    for (int c = 0; c < 3000; c++) begin
      logic [BLK_W-1:0] fbk;
      fbk = 12'h010 + BLK_W'($urandom_range(0, 6));
      cyc($urandom_range(0, 99) < 60,
          {12'h010 + BLK_W'($urandom_range(0, 6)), OFF_W'($urandom)},
          ID_W'($urandom), TAG_W'($urandom),
          $urandom_range(0, 99) < 15, fbk, $urandom_range(0, 99) < 70, "random");
    end

    for (int c = 0; c < 400 && nvalid() > 0; c++) begin
      fb_i = -1;
      for (int s = 0; s < MS; s++) if (m_v[s] && !m_dr[s]) fb_i = s;
      cyc(0, 0, 0, 0, fb_i >= 0, (fb_i >= 0) ? m_blk[fb_i] : '0, 1, "drain");
    end
    chk(nvalid() == 0, "R8 all entries freed", nvalid(), 0);
    cyc(1, 16'h0777, 1, 1, 0, 0, 1, "R8");
    cyc(0, 0, 0, 0, 0, 0, 1, "R4");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule